// File: doc/BRIEF.md
# Multi-Channel Alarm Status Interrupt Controller

This block gathers line-condition flags from four line-interface channels and turns them into a single active-low interrupt for a host. Each channel presents eight detector flags. The block registers them into a per-channel status view. Each channel also has its own mask register. Three flags are treated as alarms, and any change in their level, rising or falling, leaves an interrupt pending. The other five are events, and only a rising level leaves an interrupt pending. When the host reads a channel's status register, every pending bit in that channel is released, even if an alarm is still present.

The host reaches each channel through a small synchronous register bus. A 2-bit channel number and a 5-bit offset select the register, and read data appear one cycle after the read strobe. To find the source of an interrupt quickly, the host can read a summary byte from the upper offset window of any channel. That byte has one bit per channel, and the bit is set while that channel has an unmasked pending bit.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Reading offset 06h of a channel returns that channel's registered flag levels with this bit layout: bit 7 loop-up code, bit 6 loop-down code, bit 5 transmit clock lost, bit 4 unframed all-ones, bit 3 carrier lost, bit 2 transmit current limit, bit 1 transmit open circuit, bit 0 PRBS found. After reset, every status bit reads 0.
- R2: On bits 5, 4 and 3, a rise or a fall of the flag leaves that bit pending.
- R3: A status read releases a pending alarm bit even while the alarm flag stays high. The alarm does not become pending again until its flag changes once more.
- R4: On bits 7, 6, 2, 1 and 0, only a rise of the flag leaves the bit pending. A fall has no effect.
- R5: The mask register at offset 07h can be read and written, and it resets to FFh. A mask bit of 1 keeps its pending bit away from the interrupt output. A masked pending bit is still held, so it drives the output once its mask bit is cleared.
- R6: `irq_n` is low while any channel has a pending bit whose mask bit is 0. It goes high only when no such bit remains in any channel.
- R7: In the summary byte, bit k is 1 while channel k (0 to 3) has an unmasked pending bit. Bits 7 to 4 read as 0.
- R8: A read of any offset from 16h to 1Fh returns the summary byte, whichever channel is selected. Any other offset besides 06h and 07h reads as 00h.
- R9: Writes to offset 06h or to the summary offsets change no register.
- R10: If a flag change reaches a bit in the same cycle as a status read of its channel, the bit stays pending after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| det_i | input | 32 | Detector flags; channel k uses bits 8k+7 to 8k |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 selects a write, 0 selects a read |
| bus_ch | input | 2 | Channel number |
| bus_off | input | 5 | Register offset within the channel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after a read strobe |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The bench drives a single alarm bit through a rise and then a fall, and a single event bit through the same pair. This shows whether both edges or only the rising edge leave a bit pending, and whether a read really releases an alarm that is still present. It sets flags in two channels at once and reads only one of them, which shows whether the output waits for every channel to clear. It also reads the summary through several channels and offsets to separate address decode from channel selection. Writes to read-only offsets and masked flags are checked at the mask readback and at `irq_n`. A read placed exactly on the cycle in which a change is detected shows whether the new pending bit survives the read.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int ST_W  = 8;
  localparam int OFF_W = 5;
  // bits that interrupt on both edges: tx clock lost, unframed ones, carrier lost
  localparam logic [ST_W-1:0] ALARM_BITS = 8'b0011_1000;
  localparam logic [OFF_W-1:0] STATUS_OFF = 5'h06;
  localparam logic [OFF_W-1:0] MASK_OFF   = 5'h07;
  localparam logic [OFF_W-1:0] SUM_LO     = 5'h16;
  localparam logic [OFF_W-1:0] SUM_HI     = 5'h1F;
endpackage

// File: rtl/alarm_chan.sv
module alarm_chan
  import alarm_irq_pkg::*;
#(
  parameter int W = ST_W,
  parameter logic [W-1:0] BOTH_EDGE = ALARM_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] det_i,
  input  logic         rd_st_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] cur_q, prev_q, pend_q, mask_q;
  logic [W-1:0] pend_d, mask_d, set_v;

  always_comb begin
    set_v  = ((cur_q ^ prev_q) & BOTH_EDGE) | ((cur_q & ~prev_q) & ~BOTH_EDGE);
    pend_d = (rd_st_i ? '0 : pend_q) | set_v;
    mask_d = wr_mask_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      cur_q  <= det_i;
      prev_q <= cur_q;
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign status_o = cur_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(pend_q & ~mask_q);

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (BOTH_EDGE[i]) begin : g_alarm
      p_alarm_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q[i] != prev_q[i]) |=> pend_q[i]);
      p_alarm_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st_i && cur_q[i] == prev_q[i]) |=> !pend_q[i]);
    end else begin : g_event
      p_event_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q[i] && !prev_q[i]) |=> pend_q[i]);
      p_event_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q[i] && !cur_q[i]) |=> !pend_q[i]);
    end
  end

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask_i |=> $stable(mask_q));
endmodule

// File: rtl/alarm_bus_if.sv
module alarm_bus_if
  import alarm_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int W      = ST_W,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [CH_W-1:0]     bus_ch,
  input  logic [OFF_W-1:0]    bus_off,
  input  logic [NUM_CH*W-1:0] status_all,
  input  logic [NUM_CH*W-1:0] mask_all,
  input  logic [NUM_CH-1:0]   chan_irq,
  output logic [NUM_CH-1:0]   rd_st,
  output logic [NUM_CH-1:0]   wr_mask,
  output logic [W-1:0]        rdata_q
);
  logic          is_st, is_mask, is_sum, rd_en;
  logic [W-1:0]  rdata_d, summary;

  always_comb begin
    is_st   = (bus_off == STATUS_OFF);
    is_mask = (bus_off == MASK_OFF);
    is_sum  = (bus_off >= SUM_LO) && (bus_off <= SUM_HI);
    rd_en   = bus_sel && !bus_wr;
    summary = W'(chan_irq);
    if (is_st)        rdata_d = status_all[bus_ch*W +: W];
    else if (is_mask) rdata_d = mask_all[bus_ch*W +: W];
    else if (is_sum)  rdata_d = summary;
    else              rdata_d = '0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strb
    assign rd_st[c]   = rd_en && is_st && (bus_ch == CH_W'(c));
    assign wr_mask[c] = bus_sel && bus_wr && is_mask && (bus_ch == CH_W'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_st, wr_mask}));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH*ST_W-1:0] det_i,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [CH_W-1:0]        bus_ch,
  input  logic [OFF_W-1:0]       bus_off,
  input  logic [ST_W-1:0]        bus_wdata,
  output logic [ST_W-1:0]        bus_rdata,
  output logic                   irq_n
);
  logic [1:0]              rst_sync_q;
  logic                    rst_n_s;
  logic [NUM_CH*ST_W-1:0]  status_all, mask_all;
  logic [NUM_CH-1:0]       chan_irq, rd_st, wr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    alarm_chan #(.W(ST_W), .BOTH_EDGE(ALARM_BITS)) i_chan (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .det_i     (det_i[c*ST_W +: ST_W]),
      .rd_st_i   (rd_st[c]),
      .wr_mask_i (wr_mask[c]),
      .wdata_i   (bus_wdata),
      .status_o  (status_all[c*ST_W +: ST_W]),
      .mask_o    (mask_all[c*ST_W +: ST_W]),
      .irq_o     (chan_irq[c])
    );
  end

  alarm_bus_if #(.NUM_CH(NUM_CH), .W(ST_W)) i_bus (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_ch     (bus_ch),
    .bus_off    (bus_off),
    .status_all (status_all),
    .mask_all   (mask_all),
    .chan_irq   (chan_irq),
    .rd_st      (rd_st),
    .wr_mask    (wr_mask),
    .rdata_q    (bus_rdata)
  );

  assign irq_n = ~|chan_irq;

  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_sel && bus_wr && bus_off != MASK_OFF) |=> $stable(mask_all));
endmodule

// File: tb/test_alarm_irq_ctrl.sv
module test_alarm_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] det;
  logic        sel, wr;
  logic [1:0]  ch;
  logic [4:0]  off;
  logic [7:0]  wdata, rdata;
  logic        irq_n;
  int          total = 0, bad = 0;

  always #2ns clk = ~clk;

  alarm_irq_ctrl i_alarm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .det_i(det), .bus_sel(sel), .bus_wr(wr),
    .bus_ch(ch), .bus_off(off), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] c, input logic [4:0] o, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; ch = c; off = o; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] c, input logic [4:0] o, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; ch = c; off = o;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R6 reset irq_n", irq_n, 1);
    bus_read(2'd1, 5'h07, d); chk("R5 mask reset", d, 8'hFF);
    bus_read(2'd1, 5'h06, d); chk("R1 status reset", d, 8'h00);
    bus_read(2'd0, 5'h16, d); chk("R7 summary reset", d, 8'h00);
  endtask

  task automatic t_alarm_edges();
    logic [7:0] d;
    bus_write(2'd0, 5'h07, 8'h00);
    @(negedge clk); det[3] = 1'b1; settle();
    chk("R2 alarm rise irq", irq_n, 0);
    bus_read(2'd0, 5'h16, d); chk("R7 summary ch0", d, 8'h01);
    bus_read(2'd0, 5'h06, d); chk("R1 carrier bit3", d, 8'h08);
    chk("R3 ack while alarm held", irq_n, 1);
    settle(); chk("R3 no re-raise", irq_n, 1);
    @(negedge clk); det[3] = 1'b0; settle();
    chk("R2 alarm fall irq", irq_n, 0);
    bus_read(2'd0, 5'h06, d); chk("R1 status cleared", d, 8'h00);
    chk("R2 fall acked", irq_n, 1);
    @(negedge clk); det[7] = 1'b1; settle();
    bus_read(2'd0, 5'h06, d); chk("R1 loop-up bit7", d, 8'h80);
    @(negedge clk); det[7] = 1'b0; settle();
    chk("R4 loop-up fall ignored", irq_n, 1);
  endtask

  task automatic t_event_summary();
    logic [7:0] d;
    bus_write(2'd2, 5'h07, 8'h00);
    @(negedge clk); det[16] = 1'b1; settle();
    chk("R4 event rise irq", irq_n, 0);
    bus_read(2'd1, 5'h1F, d); chk("R8 summary via ch1 1F", d, 8'h04);
    bus_read(2'd3, 5'h18, d); chk("R8 summary via ch3 18", d, 8'h04);
    bus_read(2'd2, 5'h06, d); chk("R1 prbs bit0", d, 8'h01);
    chk("R4 event acked", irq_n, 1);
    @(negedge clk); det[16] = 1'b0; settle();
    chk("R4 event fall ignored", irq_n, 1);
    bus_read(2'd2, 5'h16, d); chk("R7 summary idle", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    @(negedge clk); det[30] = 1'b1; settle();
    chk("R5 masked no irq", irq_n, 1);
    bus_read(2'd0, 5'h16, d); chk("R5 masked summary", d, 8'h00);
    bus_write(2'd3, 5'h07, 8'hBF); @(negedge clk);
    chk("R5 unmask releases held", irq_n, 0);
    bus_read(2'd3, 5'h07, d); chk("R5 mask readback", d, 8'hBF);
    bus_read(2'd3, 5'h06, d); chk("R1 loop-down bit6", d, 8'h40);
    chk("R5 acked", irq_n, 1);
    @(negedge clk); det[30] = 1'b0;
    bus_write(2'd3, 5'h07, 8'hFF); settle();
  endtask

  task automatic t_ro_writes();
    logic [7:0] d;
    bus_write(2'd0, 5'h06, 8'hFF);
    bus_write(2'd0, 5'h16, 8'hFF);
    bus_write(2'd0, 5'h1F, 8'hFF);
    bus_read(2'd0, 5'h07, d); chk("R9 mask unchanged", d, 8'h00);
    chk("R9 no irq", irq_n, 1);
    bus_read(2'd0, 5'h16, d); chk("R9 summary unchanged", d, 8'h00);
    bus_read(2'd0, 5'h05, d); chk("R8 other offset zero", d, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk); det[4] = 1'b1;
    @(negedge clk); sel = 1'b1; wr = 1'b0; ch = 2'd0; off = 5'h06;
    @(negedge clk); sel = 1'b0; d = rdata;
    chk("R10 read data", d, 8'h10);
    chk("R10 set wins over read", irq_n, 0);
    bus_read(2'd0, 5'h06, d); chk("R10 later ack", irq_n, 1);
    @(negedge clk); det[4] = 1'b0; settle();
    bus_read(2'd0, 5'h06, d); chk("R2 unframed fall acked", irq_n, 1);
  endtask

  task automatic t_two_channels();
    logic [7:0] d;
    bus_write(2'd1, 5'h07, 8'h00);
    @(negedge clk); det[1] = 1'b1; det[13] = 1'b1; settle();
    bus_read(2'd2, 5'h1A, d); chk("R7 two channels", d, 8'h03);
    bus_read(2'd0, 5'h06, d); chk("R6 still low", irq_n, 0);
    bus_read(2'd0, 5'h16, d); chk("R7 ch1 only", d, 8'h02);
    bus_read(2'd1, 5'h06, d); chk("R1 tx clock bit5", d, 8'h20);
    chk("R6 released", irq_n, 1);
    @(negedge clk); det[1] = 1'b0; det[13] = 1'b0; settle();
    chk("R2 ch1 fall", irq_n, 0);
    bus_read(2'd1, 5'h06, d); chk("R6 final", irq_n, 1);
  endtask

  initial begin
    #400us;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; det = '0; sel = 1'b0; wr = 1'b0; ch = '0; off = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_alarm_edges();
    t_event_summary();
    t_mask();
    t_ro_writes();
    t_collision();
    t_two_channels();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule